// File: doc/BRIEF.md
# Two-Beat Triangle Record Store

This block holds the per-triangle records that a scanline rasteriser works from. A record is 405 bits wide. It carries the triangle's signed fixed-point gradients and other constants, plus a set of unsigned running values that the rasteriser advances on every scanline. The backing memory has 512 rows of 224 bits. A record does not fit in one row, so each triangle slot uses two adjacent rows. The memory therefore holds 256 slots, and every access to a record takes two memory cycles.

The block runs as a queue of slots. A producer pushes whole records. A consumer pops them in push order. The rasteriser can rewrite the running-value segment of any slot by number, and that rewrite leaves the constant part of the record untouched. The memory has one port with one cycle of read latency. A controller orders the row accesses, prefetches the oldest record into an output register, and performs rewrites as a read followed by a merged write.

Top module: `tri_record_store`

## Requirements
- R1: Slot k uses memory rows 2k and 2k+1. The low row holds record bits 223:0. The high row holds bits 404:224, padded with zeros. A record that is pushed and later popped comes back with all 405 bits intact, including every bit above 223.
- R2: Records are popped in the order they were pushed. The n-th push after reset (n counted from 0) goes into slot n mod 256.
- R3: When all 256 slots are occupied, `push_ready` stays low.
- R4: When no slot is occupied, `pop_valid` stays low.
- R5: Once `pop_valid` is high, it stays high and `pop_rec` does not change until a cycle in which `pop_ready` is high.
- R6: A rewrite of slot k with `rw_run` replaces record bits 137:0 of that slot and leaves bits 404:138 unchanged. Within bits 137:0 the fields are: Xa at 19:0, Xb at 39:20, current Y at 49:40, Z at 75:50, R at 97:76, G at 119:98, and B at 137:120.
- R7: While the record of slot k is being presented on `pop_rec` with `pop_valid` high, a rewrite that targets slot k is not accepted (`rw_ready` is low).
- R8: In the cycle after a push is accepted, `push_ready` is low while the second beat is written.
- R9: After reset, `push_ready` and `rw_ready` are high and `pop_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_valid | input | 1 | A new record is offered |
| push_ready | output | 1 | The store accepts the offered record |
| push_rec | input | 405 | Record to store |
| pop_valid | output | 1 | The oldest record is presented |
| pop_ready | input | 1 | The consumer takes the presented record |
| pop_rec | output | 405 | The oldest record, reassembled from two rows |
| rw_valid | input | 1 | A running-value rewrite is requested |
| rw_ready | output | 1 | The rewrite is accepted |
| rw_slot | input | 8 | Slot number to rewrite |
| rw_run | input | 138 | New running-value segment |

## Verification
The assertions assume that the rasteriser rewrites only occupied slots, and that a requester keeps its payload steady while it waits for ready. The random stimulus picks rewrite targets from a bench model of the occupied slots and never picks the slot at the head. Each request is held until its handshake completes. The only rewrite of the presented slot is a directed case that is withdrawn before it is ever accepted.

// File: rtl/tri_store_pkg.sv
package tri_store_pkg;

    parameter int REC_W = 405;
    parameter int ROW_W = 224;
    parameter int ROWS  = 512;
    parameter int RUN_W = 138;

    localparam int SLOTS  = ROWS / 2;
    localparam int SLOT_W = $clog2(SLOTS);
    localparam int ADDR_W = $clog2(ROWS);
    localparam int CNT_W  = $clog2(SLOTS + 1);
    localparam int HI_W   = REC_W - ROW_W;

    // running-value segment, occupying record bits RUN_W-1:0
    typedef struct packed {
        logic [17:0] b_run;
        logic [21:0] g_run;
        logic [21:0] r_run;
        logic [25:0] z_run;
        logic [9:0]  y_run;
        logic [19:0] xb_run;
        logic [19:0] xa_run;
    } run_seg_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_HI,
        ST_RD_HI,
        ST_ASSEMBLE,
        ST_MERGE
    } ctl_state_t;

    function automatic logic [ROW_W-1:0] low_beat(input logic [REC_W-1:0] rec);
        return rec[ROW_W-1:0];
    endfunction

    function automatic logic [ROW_W-1:0] high_beat(input logic [REC_W-1:0] rec);
        logic [ROW_W-1:0] row;
        row = '0;
        row[HI_W-1:0] = rec[REC_W-1:ROW_W];
        return row;
    endfunction

    function automatic logic [REC_W-1:0] join_beats(input logic [ROW_W-1:0] hi,
                                                    input logic [ROW_W-1:0] lo);
        return {hi[HI_W-1:0], lo};
    endfunction

    function automatic logic [ROW_W-1:0] merge_run(input logic [ROW_W-1:0] row,
                                                   input run_seg_t run);
        return {row[ROW_W-1:RUN_W], run};
    endfunction

endpackage

// File: rtl/tri_row_mem.sv
module tri_row_mem
    import tri_store_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic              re,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ROW_W-1:0]  wdata,
    output logic [ROW_W-1:0]  rdata
);

    logic [ROW_W-1:0] rows_q [ROWS];

    always_ff @(posedge clk) begin
        if (we) begin
            rows_q[addr] <= wdata;
        end else if (re) begin
            rdata <= rows_q[addr];
        end
    end

    // R1
    port_excl_chk: assert property (@(posedge clk) disable iff (rst) !(we && re));

endmodule

// File: rtl/tri_slot_tracker.sv
module tri_slot_tracker
    import tri_store_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              add_slot,
    input  logic              drop_slot,
    output logic [SLOT_W-1:0] head,
    output logic [SLOT_W-1:0] tail,
    output logic              full,
    output logic              empty
);

    logic [CNT_W-1:0] used_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            head   <= '0;
            tail   <= '0;
            used_q <= '0;
        end else begin
            if (add_slot)  tail <= tail + 1'b1;
            if (drop_slot) head <= head + 1'b1;
            case ({add_slot, drop_slot})
                2'b10:   used_q <= used_q + 1'b1;
                2'b01:   used_q <= used_q - 1'b1;
                default: used_q <= used_q;
            endcase
        end
    end

    assign full  = (used_q == CNT_W'(SLOTS));
    assign empty = (used_q == '0);

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        full |-> !add_slot || drop_slot);

    // R4
    no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        empty |-> !drop_slot);

endmodule

// File: rtl/tri_record_store.sv
module tri_record_store
    import tri_store_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             push_valid,
    output logic             push_ready,
    input  logic [404:0]     push_rec,
    output logic             pop_valid,
    input  logic             pop_ready,
    output logic [404:0]     pop_rec,
    input  logic             rw_valid,
    output logic             rw_ready,
    input  logic [7:0]       rw_slot,
    input  logic [137:0]     rw_run
);

    ctl_state_t        state_q;
    logic [ROW_W-1:0]  hi_hold_q;
    logic [ROW_W-1:0]  lo_hold_q;
    logic [REC_W-1:0]  out_rec_q;
    logic              out_vld_q;
    logic [SLOT_W-1:0] rw_slot_q;
    run_seg_t          rw_run_q;

    logic              mem_we;
    logic              mem_re;
    logic [ADDR_W-1:0] mem_addr;
    logic [ROW_W-1:0]  mem_wdata;
    logic [ROW_W-1:0]  mem_rdata;

    logic [SLOT_W-1:0] head;
    logic [SLOT_W-1:0] tail;
    logic              full;
    logic              empty;

    logic rw_go;
    logic fetch_go;
    logic push_go;
    logic pop_go;

    assign rw_ready   = (state_q == ST_IDLE) && !(out_vld_q && (rw_slot == head));
    assign rw_go      = rw_valid && rw_ready;
    assign fetch_go   = (state_q == ST_IDLE) && !rw_valid && !out_vld_q && !empty;
    assign push_ready = (state_q == ST_IDLE) && !rw_valid && (out_vld_q || empty) && !full;
    assign push_go    = push_valid && push_ready;
    assign pop_go     = out_vld_q && pop_ready;
    assign pop_valid  = out_vld_q;
    assign pop_rec    = out_rec_q;

    always_comb begin
        mem_we    = 1'b0;
        mem_re    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (state_q)
            ST_IDLE: begin
                if (rw_go) begin
                    mem_re   = 1'b1;
                    mem_addr = {rw_slot, 1'b0};
                end else if (fetch_go) begin
                    mem_re   = 1'b1;
                    mem_addr = {head, 1'b0};
                end else if (push_go) begin
                    mem_we    = 1'b1;
                    mem_addr  = {tail, 1'b0};
                    mem_wdata = low_beat(push_rec);
                end
            end
            ST_WR_HI: begin
                mem_we    = 1'b1;
                mem_addr  = {tail, 1'b1};
                mem_wdata = hi_hold_q;
            end
            ST_RD_HI: begin
                mem_re   = 1'b1;
                mem_addr = {head, 1'b1};
            end
            ST_MERGE: begin
                mem_we    = 1'b1;
                mem_addr  = {rw_slot_q, 1'b0};
                mem_wdata = merge_run(mem_rdata, rw_run_q);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            out_vld_q <= 1'b0;
            hi_hold_q <= '0;
            lo_hold_q <= '0;
            out_rec_q <= '0;
            rw_slot_q <= '0;
            rw_run_q  <= '0;
        end else begin
            if (pop_go) out_vld_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (rw_go) begin
                        rw_slot_q <= rw_slot;
                        rw_run_q  <= rw_run;
                        state_q   <= ST_MERGE;
                    end else if (fetch_go) begin
                        state_q <= ST_RD_HI;
                    end else if (push_go) begin
                        hi_hold_q <= high_beat(push_rec);
                        state_q   <= ST_WR_HI;
                    end
                end
                ST_WR_HI: state_q <= ST_IDLE;
                ST_RD_HI: begin
                    lo_hold_q <= mem_rdata;
                    state_q   <= ST_ASSEMBLE;
                end
                ST_ASSEMBLE: begin
                    out_rec_q <= join_beats(mem_rdata, lo_hold_q);
                    out_vld_q <= 1'b1;
                    state_q   <= ST_IDLE;
                end
                ST_MERGE: state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    tri_row_mem u_mem (
        .clk   (clk),
        .rst   (rst),
        .we    (mem_we),
        .re    (mem_re),
        .addr  (mem_addr),
        .wdata (mem_wdata),
        .rdata (mem_rdata)
    );

    tri_slot_tracker u_track (
        .clk       (clk),
        .rst       (rst),
        .add_slot  (state_q == ST_WR_HI),
        .drop_slot (pop_go),
        .head      (head),
        .tail      (tail),
        .full      (full),
        .empty     (empty)
    );

    // R5
    pop_hold_chk: assert property (@(posedge clk) disable iff (rst)
        pop_valid && !pop_ready |=> pop_valid && $stable(pop_rec));

    // R8
    second_beat_chk: assert property (@(posedge clk) disable iff (rst)
        push_valid && push_ready |=> !push_ready);

    // R4
    empty_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        empty |-> !pop_valid);

    // R7
    head_guard_chk: assert property (@(posedge clk) disable iff (rst)
        rw_valid && rw_ready && pop_valid |-> rw_slot != head);

endmodule

// File: tb/tri_record_store_bench.sv
module tri_record_store_bench;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         push_valid = 1'b0;
    logic         push_ready;
    logic [404:0] push_rec = '0;
    logic         pop_valid;
    logic         pop_ready = 1'b0;
    logic [404:0] pop_rec;
    logic         rw_valid = 1'b0;
    logic         rw_ready;
    logic [7:0]   rw_slot = '0;
    logic [137:0] rw_run = '0;

    int vectors = 0;
    int errors  = 0;

    logic [404:0] model [256];
    logic [7:0]   mh = '0;
    logic [7:0]   mt = '0;
    int           mcount = 0;

    always #2 clk = ~clk;

    tri_record_store u_tri_record_store (
        .clk(clk), .rst(rst),
        .push_valid(push_valid), .push_ready(push_ready), .push_rec(push_rec),
        .pop_valid(pop_valid), .pop_ready(pop_ready), .pop_rec(pop_rec),
        .rw_valid(rw_valid), .rw_ready(rw_ready), .rw_slot(rw_slot), .rw_run(rw_run)
    );

    function automatic logic [404:0] rand_rec();
        logic [415:0] t;
        for (int i = 0; i < 13; i++) t[i*32 +: 32] = $urandom;
        return t[404:0];
    endfunction

    function automatic logic [137:0] rand_run();
        logic [159:0] t;
        for (int i = 0; i < 5; i++) t[i*32 +: 32] = $urandom;
        return t[137:0];
    endfunction

    function automatic logic [404:0] apply_run(input logic [404:0] rec, input logic [137:0] run);
        return {rec[404:138], run};
    endfunction

    task automatic check(input bit ok, input string req, input logic [404:0] act, input logic [404:0] exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_push(input logic [404:0] r);
        @(negedge clk);
        push_valid = 1'b1;
        push_rec   = r;
        while (!push_ready) @(negedge clk);
        @(posedge clk);
        #1 push_valid = 1'b0;
        model[mt] = r;
        mt++;
        mcount++;
        @(negedge clk);
        // R8: second beat occupies the cycle after acceptance
        check(!push_ready, "R8", 405'(push_ready), 405'(0));
    endtask

    task automatic do_pop(input bit hold);
        logic [404:0] exp;
        logic [404:0] seen;
        @(negedge clk);
        while (!pop_valid) @(negedge clk);
        exp = model[mh];
        if (hold) begin
            seen = pop_rec;
            repeat (2) @(negedge clk);
            // R5
            check(pop_valid && pop_rec == seen, "R5", pop_rec, seen);
        end
        // R1: upper beat returns intact
        check(pop_rec[404:224] == exp[404:224], "R1", pop_rec, exp);
        // R2: push order and slot numbering
        check(pop_rec == exp, "R2", pop_rec, exp);
        pop_ready = 1'b1;
        @(posedge clk);
        #1 pop_ready = 1'b0;
        mh++;
        mcount--;
    endtask

    task automatic do_rewrite(input logic [7:0] slot, input logic [137:0] run);
        @(negedge clk);
        rw_valid = 1'b1;
        rw_slot  = slot;
        rw_run   = run;
        while (!rw_ready) @(negedge clk);
        @(posedge clk);
        #1 rw_valid = 1'b0;
        model[slot] = apply_run(model[slot], run);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        logic [404:0] orig5;
        logic [137:0] run5;
        logic [7:0]   slot;
        void'($urandom(32'd20160609));

        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R9
        check(push_ready && rw_ready && !pop_valid, "R9",
              405'({push_ready, rw_ready, pop_valid}), 405'(3'b110));

        // fill every slot
        for (int i = 0; i < 256; i++) do_push(rand_rec());
        repeat (6) @(negedge clk);
        push_valid = 1'b1;
        push_rec   = rand_rec();
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            // R3
            check(!push_ready, "R3", 405'(push_ready), 405'(0));
        end
        push_valid = 1'b0;

        // R7: rewrite of presented slot 0 held off
        @(negedge clk);
        rw_valid = 1'b1;
        rw_slot  = 8'd0;
        rw_run   = rand_run();
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(pop_valid && !rw_ready, "R7", 405'(rw_ready), 405'(0));
        end
        rw_valid = 1'b0;

        // R6: rewrite slot 5, check at the ports when it is popped
        orig5 = model[5];
        run5  = rand_run();
        do_rewrite(8'd5, run5);
        for (int i = 0; i < 5; i++) do_pop(i == 0);
        @(negedge clk);
        while (!pop_valid) @(negedge clk);
        check(pop_rec == {orig5[404:138], run5}, "R6", pop_rec, {orig5[404:138], run5});
        check(pop_rec[404:138] == orig5[404:138], "R6", pop_rec, orig5);
        while (mcount > 0) do_pop($urandom % 4 == 0);

        repeat (8) @(negedge clk);
        // R4
        check(!pop_valid, "R4", 405'(pop_valid), 405'(0));

        // corner: all-ones and all-zero records
        do_push('1);
        do_push('0);
        do_pop(1'b0);
        do_pop(1'b0);

        // random mix
        for (int n = 0; n < 900; n++) begin
            int op;
            op = $urandom % 3;
            if (op == 0 && mcount < 256) begin
                do_push(rand_rec());
            end else if (op == 1 && mcount > 0) begin
                do_pop($urandom % 3 == 0);
            end else if (op == 2 && mcount > 1) begin
                slot = mh + 8'(1 + ($urandom % (mcount - 1)));
                do_rewrite(slot, rand_run());
            end else if (mcount < 256) begin
                do_push(rand_rec());
            end
        end
        while (mcount > 0) do_pop(1'b0);
        repeat (8) @(negedge clk);
        // R4
        check(!pop_valid, "R4", 405'(pop_valid), 405'(0));

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule